// File: doc/BRIEF.md
# Virtual Interrupt Priority Update Unit

This block keeps the priority state of a virtualized interrupt controller. It holds a 32-bit virtual task-priority register, a 32-bit virtual processor-priority register, and two 256-bit vectors: in-service and request. These are reached through a 32-bit, byte-offset-addressed port that follows the layout of a 4 KB register page. An 8-bit servicing-vector input comes from the surrounding logic.

Processor priority is recomputed only when one of three single-cycle events arrives: an entry event, an end-of-interrupt event, or a task-priority event. At all other times it holds its last value. A task-priority event is a page write to offset 080h, or one of two alternate-path write strobes. A small sequencer then decides the follow-up. With virtual-interrupt delivery off, it compares the new task priority against a threshold and may raise a one-cycle exit request. With delivery on, it recomputes processor priority and then pulses an evaluate-pending output. That output carries the index of the highest pending request.

The sequencer has four states:
- IDLE: waiting.
- CHECK: the cycle after a task-priority write has been committed.
- EXIT: the threshold exit request is high.
- EVAL: the evaluate-pending pulse is high.

Its transitions are:
- IDLE→CHECK on a task-priority event. Any state also goes to CHECK on a new task-priority event.
- CHECK→EVAL when delivery is on.
- CHECK→EXIT when delivery is off and the priority class is below the threshold.
- CHECK→IDLE when delivery is off and the class is not below the threshold.
- EXIT→IDLE and EVAL→IDLE unconditionally.
- Any state→IDLE on an entry event.

Top module: `vprio_unit`

## Requirements
- R1: Reset sets every register, the sequencer (to IDLE) and every output to zero.
- R2: Only aligned accesses (byte offset bits [1:0] = 0) reach the register page:
  - Task priority is a full 32-bit read/write register at 080h.
  - Processor priority is readable and writable at 0A0h.
  - In-service bit x lives at bit (x & 1Fh) of the dword at 100h | ((x & E0h) >> 1). Request bit x uses the same mapping with base 200h.
  - Unaligned or unmapped writes change nothing, and unmapped reads return zero.
- R3: In each 16-byte slot of 100h–17Fh and 200h–27Fh, only the dword at slot offset 0 is storage. The other 12 bytes read zero, and writes to them are ignored.
- R4: A recomputation sets processor priority to the full task-priority low byte when task[7:4] ≥ servicing[7:4], and otherwise to servicing & F0h. It always zeroes bits [31:8].
- R5: Processor priority is recomputed only on an entry event, an end-of-interrupt event, or a task-priority event with delivery on. Changes to the servicing vector, the in-service or request vectors, or task priority with delivery off leave it unchanged.
- R6: A task-priority event is a page write to 080h, a control-register strobe, or an MSR strobe. The alternate strobes load the 8-bit alternate data zero-extended. A page write in the same cycle wins over them.
- R7: With delivery off, a task-priority event commits the new value at the event's clock edge. One cycle later the exit request is high for exactly one cycle if task[7:4] is strictly below the 4-bit threshold.
- R8: With delivery on, processor priority is updated at the edge after the commit. In the same cycle that the updated value becomes readable, the evaluate-pending pulse is high for one cycle. No exit request is raised.
- R9: During the evaluate-pending pulse:
  - If the request vector is non-empty, the index output carries the highest set request bit and the valid flag is high.
  - If it is empty, the valid flag is low.
  - Outside the pulse, both the index and the flag are zero.
- R10: An entry event recomputes processor priority using the task priority held before that edge. It cancels any follow-up from a same-cycle or earlier task-priority event, so no exit or evaluate pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_wr | input | 1 | Register page write strobe |
| pg_addr | input | 12 | Byte offset for read and write |
| pg_wdata | input | 32 | Write data |
| pg_rdata | output | 32 | Read data for pg_addr (combinational) |
| cr_tpr_wr | input | 1 | Control-register path task-priority write strobe |
| msr_tpr_wr | input | 1 | MSR path task-priority write strobe |
| alt_tpr_data | input | 8 | Data for the alternate-path strobes |
| eoi_evt | input | 1 | End-of-interrupt event pulse |
| entry_evt | input | 1 | Entry event pulse |
| svc_vec | input | 8 | Servicing vector |
| vid_en | input | 1 | Virtual-interrupt delivery enable |
| tpr_thresh | input | 4 | Threshold for the exit comparison |
| exit_req | output | 1 | Threshold exit request, one cycle |
| eval_pulse | output | 1 | Evaluate-pending pulse, one cycle |
| eval_vec | output | 8 | Highest pending request index during the pulse |
| eval_valid | output | 1 | Request vector non-empty during the pulse |

## Verification
The bench sweeps every task-priority byte against all sixteen servicing classes, with non-zero servicing low bits. A wrong comparison direction, a failure to mask F0h, or truncation of task priority to its high nibble all show up as a wrong processor-priority read. It then sweeps all threshold and priority-class pairs across the three event sources. This catches an off-by-one (≤ instead of <) compare, and an exit that fires before the write commits or lasts two cycles. Every request index from 0 to 255 is placed in turn above bit 0. A low-first encoder or a wrong stripe mapping returns the wrong index. Separate cases cover:
- the unused slot bytes;
- unaligned offsets;
- the processor priority staying stale under servicing-vector changes;
- an entry event arriving together with an alternate-path write, where a design that ignored precedence would emit a stray evaluate pulse.

// File: rtl/vprio_pkg.sv
package vprio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_EXIT  = 2'd2,
        ST_EVAL  = 2'd3
    } seq_state_t;

    // Priority class compare: task wins ties, else servicing class only
    function automatic logic [7:0] ppr_calc(input logic [7:0] tpr, input logic [7:0] svc);
        if (tpr[7:4] >= svc[7:4])
            return tpr;
        else
            return svc & 8'hF0;
    endfunction

endpackage

// File: rtl/vprio_regs.sv
module vprio_regs #(
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int NVEC = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_wr,
    input  logic [AW-1:0]   pg_addr,
    input  logic [DW-1:0]   pg_wdata,
    output logic [DW-1:0]   pg_rdata,
    input  logic            alt_wr,
    input  logic [7:0]      alt_data,
    input  logic [7:0]      svc_vec,
    input  logic            ppr_load,
    output logic            tpr_evt,
    output logic [3:0]      tpr_cls,
    output logic [NVEC-1:0] irr_vec
);
    import vprio_pkg::*;

    localparam int NWORD  = NVEC / DW;
    localparam int WSEL_W = $clog2(NWORD);
    localparam int RLO    = 4 + WSEL_W;
    localparam logic [AW-1:0] TPR_OFS  = AW'('h080);
    localparam logic [AW-1:0] PPR_OFS  = AW'('h0A0);
    localparam logic [AW-1:0] ISR_BASE = AW'('h100);
    localparam logic [AW-1:0] IRR_BASE = AW'('h200);

    logic [DW-1:0]     tpr_q, ppr_q;
    logic [NVEC-1:0]   isr_q, irr_q;
    logic              hit_tpr, hit_ppr, isr_slot, irr_slot;
    logic [WSEL_W-1:0] wsel;

    assign hit_tpr  = (pg_addr == TPR_OFS);
    assign hit_ppr  = (pg_addr == PPR_OFS);
    assign isr_slot = (pg_addr[AW-1:RLO] == ISR_BASE[AW-1:RLO]) && (pg_addr[3:0] == 4'd0);
    assign irr_slot = (pg_addr[AW-1:RLO] == IRR_BASE[AW-1:RLO]) && (pg_addr[3:0] == 4'd0);
    assign wsel     = pg_addr[4 +: WSEL_W];

    assign tpr_evt  = (pg_wr && hit_tpr) || alt_wr;
    assign tpr_cls  = tpr_q[7:4];
    assign irr_vec  = irr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            tpr_q <= '0;
        else if (pg_wr && hit_tpr)
            tpr_q <= pg_wdata;
        else if (alt_wr)
            tpr_q <= {{(DW-8){1'b0}}, alt_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ppr_q <= '0;
        else if (ppr_load)
            ppr_q <= {{(DW-8){1'b0}}, ppr_calc(tpr_q[7:0], svc_vec)};
        else if (pg_wr && hit_ppr)
            ppr_q <= pg_wdata;
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                isr_q[w*DW +: DW] <= '0;
                irr_q[w*DW +: DW] <= '0;
            end else if (pg_wr && (wsel == WSEL_W'(w))) begin
                if (isr_slot) isr_q[w*DW +: DW] <= pg_wdata;
                if (irr_slot) irr_q[w*DW +: DW] <= pg_wdata;
            end
        end
    end

    always_comb begin
        pg_rdata = '0;
        if (hit_tpr)       pg_rdata = tpr_q;
        else if (hit_ppr)  pg_rdata = ppr_q;
        else if (isr_slot) pg_rdata = isr_q[int'(wsel)*DW +: DW];
        else if (irr_slot) pg_rdata = irr_q[int'(wsel)*DW +: DW];
    end

    // R4
    ppr_hi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_load |=> (ppr_q[DW-1:8] == '0));

    // R5
    ppr_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ppr_load && !(pg_wr && hit_ppr)) |=> $stable(ppr_q));

endmodule

// File: rtl/vprio_prienc.sv
module vprio_prienc #(
    parameter int NVEC = 256,
    localparam int IW  = $clog2(NVEC)
) (
    input  logic [NVEC-1:0] vec,
    output logic [IW-1:0]   idx,
    output logic            valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            if (vec[i]) begin
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vprio_seq.sv
module vprio_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tpr_evt,
    input  logic       entry_evt,
    input  logic       eoi_evt,
    input  logic       vid_en,
    input  logic [3:0] thresh,
    input  logic [3:0] tpr_cls,
    output logic       ppr_load,
    output logic       exit_req,
    output logic       eval_pulse
);
    import vprio_pkg::*;

    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        if (entry_evt)
            state_d = ST_IDLE;
        else if (tpr_evt)
            state_d = ST_CHECK;
        else begin
            unique case (state_q)
                ST_CHECK: begin
                    if (vid_en)                 state_d = ST_EVAL;
                    else if (tpr_cls < thresh)  state_d = ST_EXIT;
                    else                        state_d = ST_IDLE;
                end
                ST_EXIT:  state_d = ST_IDLE;
                ST_EVAL:  state_d = ST_IDLE;
                ST_IDLE:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        exit_req   = (state_q == ST_EXIT);
        eval_pulse = (state_q == ST_EVAL);
        ppr_load   = entry_evt || eoi_evt || ((state_q == ST_CHECK) && vid_en);
    end

    // R7
    exit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !exit_req);

    // R7
    exit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> $past(!vid_en));

    // R8
    eval_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_pulse |-> ($past(vid_en) && $past(ppr_load) && !exit_req));

    // R10
    entry_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_evt |=> (!exit_req && !eval_pulse));

endmodule

// File: rtl/vprio_unit.sv
module vprio_unit #(
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int NVEC = 256,
    localparam int IW  = $clog2(NVEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_wr,
    input  logic [AW-1:0] pg_addr,
    input  logic [DW-1:0] pg_wdata,
    output logic [DW-1:0] pg_rdata,
    input  logic          cr_tpr_wr,
    input  logic          msr_tpr_wr,
    input  logic [7:0]    alt_tpr_data,
    input  logic          eoi_evt,
    input  logic          entry_evt,
    input  logic [7:0]    svc_vec,
    input  logic          vid_en,
    input  logic [3:0]    tpr_thresh,
    output logic          exit_req,
    output logic          eval_pulse,
    output logic [IW-1:0] eval_vec,
    output logic          eval_valid
);
    logic            tpr_evt, ppr_load, enc_valid;
    logic [3:0]      tpr_cls;
    logic [NVEC-1:0] irr_vec;
    logic [IW-1:0]   enc_idx;

    vprio_regs #(.AW(AW), .DW(DW), .NVEC(NVEC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_wr    (pg_wr),
        .pg_addr  (pg_addr),
        .pg_wdata (pg_wdata),
        .pg_rdata (pg_rdata),
        .alt_wr   (cr_tpr_wr || msr_tpr_wr),
        .alt_data (alt_tpr_data),
        .svc_vec  (svc_vec),
        .ppr_load (ppr_load),
        .tpr_evt  (tpr_evt),
        .tpr_cls  (tpr_cls),
        .irr_vec  (irr_vec)
    );

    vprio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tpr_evt    (tpr_evt),
        .entry_evt  (entry_evt),
        .eoi_evt    (eoi_evt),
        .vid_en     (vid_en),
        .thresh     (tpr_thresh),
        .tpr_cls    (tpr_cls),
        .ppr_load   (ppr_load),
        .exit_req   (exit_req),
        .eval_pulse (eval_pulse)
    );

    vprio_prienc #(.NVEC(NVEC)) u_enc (
        .vec   (irr_vec),
        .idx   (enc_idx),
        .valid (enc_valid)
    );

    assign eval_vec   = eval_pulse ? enc_idx : '0;
    assign eval_valid = eval_pulse && enc_valid;

    // R9
    eval_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |-> irr_vec[eval_vec]);

endmodule

// File: tb/sim_vprio_unit.sv
module sim_vprio_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr = 1'b0;
    logic [11:0] pg_addr = '0;
    logic [31:0] pg_wdata = '0;
    logic [31:0] pg_rdata;
    logic        cr_tpr_wr = 1'b0, msr_tpr_wr = 1'b0;
    logic [7:0]  alt_tpr_data = '0;
    logic        eoi_evt = 1'b0, entry_evt = 1'b0;
    logic [7:0]  svc_vec = '0;
    logic        vid_en = 1'b0;
    logic [3:0]  tpr_thresh = '0;
    logic        exit_req, eval_pulse, eval_valid;
    logic [7:0]  eval_vec;

    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    vprio_unit u0 (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_addr(pg_addr),
        .pg_wdata(pg_wdata), .pg_rdata(pg_rdata), .cr_tpr_wr(cr_tpr_wr),
        .msr_tpr_wr(msr_tpr_wr), .alt_tpr_data(alt_tpr_data), .eoi_evt(eoi_evt),
        .entry_evt(entry_evt), .svc_vec(svc_vec), .vid_en(vid_en),
        .tpr_thresh(tpr_thresh), .exit_req(exit_req), .eval_pulse(eval_pulse),
        .eval_vec(eval_vec), .eval_valid(eval_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pg_write(input logic [11:0] a, input logic [31:0] d);
        pg_wr = 1'b1; pg_addr = a; pg_wdata = d;
        step();
        pg_wr = 1'b0;
    endtask

    task automatic pg_read(input logic [11:0] a, output logic [31:0] d);
        pg_addr = a;
        #1;
        d = pg_rdata;
    endtask

    // src 0: page write, 1: control-register strobe, 2: MSR strobe; returns in CHECK cycle
    task automatic tpr_event(input int src, input logic [7:0] v);
        if (src == 0) begin pg_wr = 1'b1; pg_addr = 12'h080; pg_wdata = {24'd0, v}; end
        else if (src == 1) begin cr_tpr_wr = 1'b1; alt_tpr_data = v; end
        else begin msr_tpr_wr = 1'b1; alt_tpr_data = v; end
        step();
        pg_wr = 1'b0; cr_tpr_wr = 1'b0; msr_tpr_wr = 1'b0;
    endtask

    function automatic logic [31:0] exp_ppr(input logic [7:0] t, input logic [7:0] s);
        if (t[7:4] >= s[7:4]) return {24'd0, t};
        return {24'd0, s[7:4], 4'd0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", nchk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd, ppr0;
        repeat (3) step();
        rst_n = 1'b1;

        // R1 reset state
        pg_read(12'h080, rd); check("R1 tpr reset", rd, 0);
        pg_read(12'h0A0, rd); check("R1 ppr reset", rd, 0);
        pg_read(12'h200, rd); check("R1 irr reset", rd, 0);
        check("R1 outputs reset", {exit_req, eval_pulse, eval_valid, eval_vec}, 0);

        // R4 R8 exhaustive task byte vs servicing class
        vid_en = 1'b1;
        for (int t = 0; t < 256; t++) begin
            tpr_event(0, t[7:0]);
            pg_read(12'h080, rd); check("R8 commit before pulse", rd, t);
            check("R8 no pulse in commit cycle", eval_pulse, 0);
            step();
            check("R8 eval pulse", eval_pulse, 1);
            check("R8 no exit", exit_req, 0);
            pg_read(12'h0A0, rd); check("R8 ppr ready with pulse", rd, exp_ppr(t[7:0], svc_vec));
            step();
            check("R8 pulse one cycle", eval_pulse, 0);
            for (int s = 0; s < 16; s++) begin
                svc_vec = {s[3:0], t[3:0] ^ 4'h5};
                eoi_evt = 1'b1;
                step();
                eoi_evt = 1'b0;
                pg_read(12'h0A0, rd);
                check("R4 ppr compare", rd, exp_ppr(t[7:0], svc_vec));
            end
        end

        // R7 R5 threshold sweep with delivery off, all three sources
        vid_en = 1'b0;
        for (int th = 0; th < 16; th++) begin
            for (int n = 0; n < 16; n++) begin
                tpr_thresh = th[3:0];
                svc_vec = {n[3:0] ^ 4'hC, 4'h3};
                pg_read(12'h0A0, ppr0);
                tpr_event((th + n) % 3, {n[3:0], th[3:0]});
                pg_read(12'h080, rd); check("R7 R6 commit visible", rd, {24'd0, n[3:0], th[3:0]});
                check("R7 no early exit", exit_req, 0);
                step();
                check("R7 exit compare", exit_req, (n < th) ? 1 : 0);
                check("R8 no eval when off", eval_pulse, 0);
                pg_read(12'h0A0, rd); check("R5 ppr stale", rd, ppr0);
                step();
                check("R7 exit one cycle", exit_req, 0);
            end
        end

        // R9 encoder: empty, then every index above bit 0
        vid_en = 1'b1;
        tpr_event(0, 8'h00);
        check("R9 quiet outside pulse", {eval_valid, eval_vec}, 0);
        step();
        check("R9 empty valid low", eval_valid, 0);
        step();
        pg_write(12'h200, 32'h1);
        for (int x = 0; x < 256; x++) begin
            logic [11:0] a;
            logic [31:0] base;
            a = 12'h200 | 12'((x & 8'hE0) >> 1);
            base = (a == 12'h200) ? 32'h1 : 32'h0;
            pg_write(a, base | (32'h1 << (x & 31)));
            tpr_event(1, 8'h10);
            step();
            check("R9 R2 highest index", {eval_valid, eval_vec}, {1'b1, x[7:0]});
            step();
            pg_write(a, base);
        end

        // R6 page write wins over alternate strobe
        pg_wr = 1'b1; pg_addr = 12'h080; pg_wdata = 32'hCAFE0042;
        cr_tpr_wr = 1'b1; alt_tpr_data = 8'h99;
        step();
        pg_wr = 1'b0; cr_tpr_wr = 1'b0;
        pg_read(12'h080, rd); check("R6 page write priority", rd, 32'hCAFE0042);
        step(); step();

        // R10 entry with same-cycle alternate write
        tpr_event(0, 8'h30);
        step(); step();
        svc_vec = 8'h5A;
        entry_evt = 1'b1; msr_tpr_wr = 1'b1; alt_tpr_data = 8'h70;
        step();
        entry_evt = 1'b0; msr_tpr_wr = 1'b0;
        pg_read(12'h0A0, rd); check("R10 ppr from old tpr", rd, 32'h50);
        pg_read(12'h080, rd); check("R10 tpr still stored", rd, 32'h70);
        step();
        check("R10 no eval after entry", {eval_pulse, exit_req}, 0);
        step();
        check("R10 no eval later", {eval_pulse, exit_req}, 0);

        // R4 R5 upper bytes and staleness
        pg_write(12'h0A0, 32'hDEADBE12);
        pg_read(12'h0A0, rd); check("R2 ppr port write", rd, 32'hDEADBE12);
        svc_vec = 8'hF1;
        step();
        pg_read(12'h0A0, rd); check("R5 svc change stale", rd, 32'hDEADBE12);
        eoi_evt = 1'b1;
        step();
        eoi_evt = 1'b0;
        pg_read(12'h0A0, rd); check("R4 upper cleared", rd, 32'hF0);

        // R2 R3 slot mapping, unused bytes, unaligned
        for (int w = 0; w < 8; w++) begin
            logic [11:0] ib, rb;
            ib = 12'h100 + 12'(w * 16);
            rb = 12'h200 + 12'(w * 16);
            pg_write(ib, 32'hA5000000 | w);
            pg_write(rb, 32'h5A000000 | w);
            for (int k = 1; k < 4; k++) begin
                pg_write(ib + 12'(k * 4), 32'hFFFFFFFF);
                pg_read(ib + 12'(k * 4), rd); check("R3 isr pad reads zero", rd, 0);
                pg_read(rb + 12'(k * 4), rd); check("R3 irr pad reads zero", rd, 0);
            end
            pg_read(ib, rd); check("R3 R2 isr dword kept", rd, 32'hA5000000 | w);
            pg_read(rb, rd); check("R2 irr dword", rd, 32'h5A000000 | w);
        end
        pg_write(12'h081, 32'h12345678);
        pg_read(12'h080, rd); check("R2 unaligned ignored", rd, 32'hCAFE0042 & 0 | 32'h70);
        pg_read(12'h081, rd); check("R2 unaligned reads zero", rd, 0);
        check("R2 unaligned no event", {eval_pulse, exit_req}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule